// File: doc/BRIEF.md
# I2C Byte-Level Bus Controller Engine

This block is the bit-level engine of an I2C controller. A host sequencer gives it one command at a time as a single-clock strobe: generate a start (or a repeated start when the engine already owns the bus), generate a stop, send one byte, or receive one byte and answer it with a chosen acknowledge. The engine drives the two bus wires through open-drain style enables: an enable of 1 pulls the wire low and 0 releases it to the pull-up. It reads the wires back through a two-flop synchronizer.

Every bus action is a fixed walk through named sub-states: pull SCL low, move SDA while SCL is low, then release SCL. The two SCL phases are timed in half-periods of a parameterised SCL period counted in system clocks. While a command runs, `busy` is high. When `busy` drops, the acknowledge seen from the target (after a send) or the assembled byte (after a receive) is valid. A small watcher on the synchronized wires reports every start and stop condition that appears on the bus.

The host is expected to sequence whole transactions itself: start, address byte, data bytes, and then a stop or a repeated start.

Top module: `i2c_byte_engine`

## Requirements
- R1: While and right after reset, `scl_oe` = 0, `sda_oe` = 0, `busy` = 0, `ack_rcvd` = 0, `rd_data` = 0x00, and both condition flags are 0.
- R2: A strobe seen while idle raises `busy` from the next clock. A strobe of any kind seen while `busy` is high has no effect: the bus frame, the byte duration, the results and the condition flags are the same as without it.
- R3: A start on a bus the engine does not own pulls SDA low while SCL stays released. The first line change is SDA falling. The command ends with SCL high and SDA low, and `start_seen` pulses once.
- R4: A start while the engine owns the bus (after a start and before a stop) first pulls SCL low, then releases SDA, releases SCL, and pulls SDA low. It ends with SCL high and SDA low, and `start_seen` pulses once.
- R5: A stop first pulls SCL low, then pulls SDA low, releases SCL, and releases SDA while SCL is high. It ends with both lines high, and `stop_seen` pulses once.
- R6: A sent byte goes out MSB first (0xA5 appears as 1,0,1,0,0,1,0,1 at the SCL rising edges). SDA changes only while SCL is low. Each SCL low phase lasts 1 + HALF clocks and each complete high phase lasts HALF clocks, where HALF = SCL_PERIOD_CYC/2.
- R7: On the ninth clock of a send, the engine releases SDA. At the end of that high phase it samples SDA: `ack_rcvd` becomes 1 when SDA was low (acknowledge) and 0 when it was high (no acknowledge).
- R8: On a receive, the engine releases SDA for eight clocks. It samples each bit at the end of the SCL high phase and places the bits MSB first into `rd_data`.
- R9: On the ninth clock of a receive, the engine pulls SDA low when `rd_ack_req` was 1 at the strobe, and leaves SDA released when it was 0.
- R10: For a byte command, `busy` stays high for exactly 9*(1+2*HALF) clocks, covering the acknowledge bit. Results are valid in the first cycle with `busy` low, and SCL is released whenever `busy` is low.
- R11: `start_seen` and `stop_seen` are single-clock pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL wire level as read from the pad |
| sda_i | input | 1 | SDA wire level as read from the pad |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cmd_start | input | 1 | Strobe: start or repeated start (highest priority) |
| cmd_stop | input | 1 | Strobe: stop condition |
| cmd_write | input | 1 | Strobe: send `wr_data` |
| cmd_read | input | 1 | Strobe: receive one byte (lowest priority) |
| wr_data | input | 8 | Byte to send, taken with the strobe |
| rd_ack_req | input | 1 | 1 = acknowledge the received byte, taken with the strobe |
| busy | output | 1 | A command is in progress |
| ack_rcvd | output | 1 | Acknowledge from the target after the last send |
| rd_data | output | 8 | Byte assembled by the last receive |
| start_seen | output | 1 | One-cycle pulse on a start condition on the bus |
| stop_seen | output | 1 | One-cycle pulse on a stop condition on the bus |

## Verification
The bench goes after the difference between a fresh and a repeated start by recording which wire moves first. An engine that ignored bus ownership would drop SDA with SCL high in the middle of a transaction, or drag SCL low on an idle bus. It checks both acknowledge polarities in both directions: an inverted sample would report a NAK as an ACK, and a wrong drive in the receive acknowledge slot would show up in the captured bus frame. It measures every complete SCL phase and counts any SDA movement with SCL high, so an off-by-one half-period or a data change on the wrong edge is caught. It also fires a burst of every strobe in the middle of a byte; an engine that re-armed on them would corrupt the frame, stretch `busy` or emit spurious conditions.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RS_SCL_L,   // repeated start: pull SCL low
    ST_RS_SDA_H,   // repeated start: release SDA, SCL low
    ST_RS_SCL_H,   // repeated start: release SCL
    ST_ST_SDA_L,   // start: pull SDA low with SCL high
    ST_SP_SCL_L,   // stop: pull SCL low
    ST_SP_SDA_L,   // stop: pull SDA low, SCL low
    ST_SP_SCL_H,   // stop: release SCL
    ST_SP_SDA_H,   // stop: release SDA with SCL high
    ST_BIT_SCL_L,  // bit: pull SCL low
    ST_BIT_SDA_N,  // bit: set SDA for this bit, SCL low
    ST_BIT_SCL_H   // bit: release SCL, sample at the end
  } eng_state_t;

  localparam int unsigned BITS_PER_BYTE = 8;

  // States in which the engine holds SCL low.
  function automatic logic scl_pulled(eng_state_t s);
    return (s == ST_RS_SCL_L) || (s == ST_RS_SDA_H) ||
           (s == ST_SP_SCL_L) || (s == ST_SP_SDA_L) ||
           (s == ST_BIT_SCL_L) || (s == ST_BIT_SDA_N);
  endfunction

  // Whether SDA is pulled low during the data phase of bit slot idx.
  // Slots 0..7 carry data, slot 8 is the acknowledge slot.
  function automatic logic bit_drive_low(logic is_read, logic [3:0] idx,
                                         logic msb, logic ack_req);
    if (idx == 4'(BITS_PER_BYTE)) return is_read & ack_req;
    return !is_read & !msb;
  endfunction

  // States in which SDA may legally move while SCL is high.
  function automatic logic cond_state(eng_state_t s);
    return (s == ST_ST_SDA_L) || (s == ST_SP_SDA_H);
  endfunction

endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '1;   // released bus reads high
        else        stage_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '1;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expire
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire = (cnt_q == LAST);

  // R6: once a half-period has run out it stays expired until restarted
  expire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && expire) |=> expire);
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_seen,
  output logic stop_seen
);
  logic scl_prev_q, sda_prev_q, start_q, stop_q;
  logic scl_steady_hi, sda_fell, sda_rose;

  assign scl_steady_hi = scl_s & scl_prev_q;
  assign sda_fell      = sda_prev_q & ~sda_s;
  assign sda_rose      = ~sda_prev_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
      start_q    <= 1'b0;
      stop_q     <= 1'b0;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
      start_q    <= scl_steady_hi & sda_fell;
      stop_q     <= scl_steady_hi & sda_rose;
    end
  end

  assign start_seen = start_q;
  assign stop_seen  = stop_q;

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));
  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !start_seen);
  // R11
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !stop_seen);
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_write,
  input  logic       cmd_read,
  input  logic [7:0] wr_data,
  input  logic       rd_ack_req,
  input  logic       sda_s,
  input  logic       half_done,
  output logic       timer_clr,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       ack_rcvd,
  output logic [7:0] rd_data
);
  eng_state_t state_q, state_d;

  logic       claimed_q, is_read_q, ack_req_q, sda_low_q, ack_q;
  logic [3:0] bit_idx_q;
  logic [7:0] wr_sh_q, rd_sh_q, rd_data_q;

  // Named events for the assertions
  logic cmd_any, accept, bit_end, last_bit, drive_bit, moving;

  assign cmd_any   = cmd_start | cmd_stop | cmd_write | cmd_read;
  assign accept    = (state_q == ST_IDLE) && cmd_any;
  assign bit_end   = (state_q == ST_BIT_SCL_H) && half_done;
  assign last_bit  = (bit_idx_q == 4'(BITS_PER_BYTE));
  assign drive_bit = bit_drive_low(is_read_q, bit_idx_q, wr_sh_q[7], ack_req_q);
  assign moving    = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_start)                  state_d = claimed_q ? ST_RS_SCL_L : ST_ST_SDA_L;
        else if (cmd_stop)              state_d = ST_SP_SCL_L;
        else if (cmd_write || cmd_read) state_d = ST_BIT_SCL_L;
      end
      ST_RS_SCL_L:  state_d = ST_RS_SDA_H;
      ST_RS_SDA_H:  if (half_done) state_d = ST_RS_SCL_H;
      ST_RS_SCL_H:  if (half_done) state_d = ST_ST_SDA_L;
      ST_ST_SDA_L:  if (half_done) state_d = ST_IDLE;
      ST_SP_SCL_L:  state_d = ST_SP_SDA_L;
      ST_SP_SDA_L:  if (half_done) state_d = ST_SP_SCL_H;
      ST_SP_SCL_H:  if (half_done) state_d = ST_SP_SDA_H;
      ST_SP_SDA_H:  if (half_done) state_d = ST_IDLE;
      ST_BIT_SCL_L: state_d = ST_BIT_SDA_N;
      ST_BIT_SDA_N: if (half_done) state_d = ST_BIT_SCL_H;
      ST_BIT_SCL_H: if (half_done) state_d = last_bit ? ST_IDLE : ST_BIT_SCL_L;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      claimed_q <= 1'b0;
      is_read_q <= 1'b0;
      ack_req_q <= 1'b0;
      sda_low_q <= 1'b0;
      ack_q     <= 1'b0;
      bit_idx_q <= '0;
      wr_sh_q   <= '0;
      rd_sh_q   <= '0;
      rd_data_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        if (cmd_start)     claimed_q <= 1'b1;
        else if (cmd_stop) claimed_q <= 1'b0;
        is_read_q <= !cmd_write;
        ack_req_q <= rd_ack_req;
        wr_sh_q   <= wr_data;
        bit_idx_q <= '0;
      end
      if (moving) begin
        case (state_d)
          ST_ST_SDA_L, ST_SP_SDA_L: sda_low_q <= 1'b1;
          ST_RS_SDA_H, ST_SP_SDA_H: sda_low_q <= 1'b0;
          ST_BIT_SDA_N:             sda_low_q <= drive_bit;
          default: ;
        endcase
      end
      if (bit_end) begin
        if (last_bit) begin
          if (is_read_q) rd_data_q <= rd_sh_q;
          else           ack_q     <= !sda_s;
        end else begin
          rd_sh_q   <= {rd_sh_q[6:0], sda_s};
          wr_sh_q   <= {wr_sh_q[6:0], 1'b0};
          bit_idx_q <= bit_idx_q + 4'd1;
        end
      end
    end
  end

  assign timer_clr = moving || (state_q == ST_IDLE);
  assign scl_low   = scl_pulled(state_q);
  assign sda_low   = sda_low_q;
  assign busy      = (state_q != ST_IDLE);
  assign ack_rcvd  = ack_q;
  assign rd_data   = rd_data_q;

  // R6: with SCL held released, SDA only moves in a start or stop state
  sda_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && !$stable(sda_low_q)) |-> cond_state(state_q));
  // R2: busy only rises after a strobe
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_any));
  // R2: strobes during a command leave the captured command untouched
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_any) |=> ($stable(is_read_q) && $stable(ack_req_q) && $stable(claimed_q)));
  // R10: bit slot never runs past the acknowledge slot
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx_q <= 4'(BITS_PER_BYTE));
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int unsigned SCL_PERIOD_CYC = 8,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_write,
  input  logic       cmd_read,
  input  logic [7:0] wr_data,
  input  logic       rd_ack_req,
  output logic       busy,
  output logic       ack_rcvd,
  output logic [7:0] rd_data,
  output logic       start_seen,
  output logic       stop_seen
);
  // Half-period must be at least 2 clocks for the sample point to see settled SDA.
  localparam int unsigned HALF_CYC = (SCL_PERIOD_CYC / 2 < 2) ? 2 : SCL_PERIOD_CYC / 2;

  logic [1:0] bus_s;
  logic       scl_s, sda_s, half_done, timer_clr;

  i2c_sync2 #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2c_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .expire(half_done)
  );

  i2c_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_write (cmd_write),
    .cmd_read  (cmd_read),
    .wr_data   (wr_data),
    .rd_ack_req(rd_ack_req),
    .sda_s     (sda_s),
    .half_done (half_done),
    .timer_clr (timer_clr),
    .scl_low   (scl_oe),
    .sda_low   (sda_oe),
    .busy      (busy),
    .ack_rcvd  (ack_rcvd),
    .rd_data   (rd_data)
  );

  i2c_bus_watch u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_seen(start_seen),
    .stop_seen (stop_seen)
  );

  // R10: the clock wire is released whenever no command runs
  idle_scl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_oe);
endmodule

// File: tb/i2c_byte_engine_test.sv
module i2c_byte_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_CYC = 8;
  localparam int HALF       = PERIOD_CYC / 2;
  localparam int BYTE_CYC   = 9 * (1 + 2 * HALF);

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_stop = 0, cmd_write = 0, cmd_read = 0;
  logic [7:0] wr_data = 0;
  logic rd_ack_req = 0;
  logic scl_oe, sda_oe, busy, ack_rcvd, start_seen, stop_seen;
  logic [7:0] rd_data;
  logic tgt_pull = 0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | tgt_pull);

  i2c_byte_engine #(.SCL_PERIOD_CYC(PERIOD_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_write(cmd_write), .cmd_read(cmd_read),
    .wr_data(wr_data), .rd_ack_req(rd_ack_req),
    .busy(busy), .ack_rcvd(ack_rcvd), .rd_data(rd_data),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- target model: presents one 9-slot pattern ----------------
  logic [8:0] tgt_bits = '1;  // line level per slot, slot 0 at bit 8
  int tgt_idx = 9;
  always @(posedge scl_oe) begin   // SCL falls
    if (tgt_idx < 9) begin
      tgt_pull = ~tgt_bits[8 - tgt_idx];
      tgt_idx++;
    end else tgt_pull = 0;
  end

  // ---------------- scoreboard monitor on SCL rising edges ----------------
  logic [8:0] exp_q[$];
  logic [8:0] mon_frame = '0;
  int mon_cnt = 9;
  always @(negedge scl_oe) begin   // SCL rises
    if (rst_n && mon_cnt < 9) begin
      mon_frame[8 - mon_cnt] = sda_line;
      mon_cnt++;
      if (mon_cnt == 9) begin
        if (exp_q.size() == 0) chk(0, "R6 R8 frame without expectation", mon_frame, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          // R6 R7 R8 R9: bit order and acknowledge slot level on the wire
          chk(mon_frame == e, "R6 R7 R8 R9 bus frame", mon_frame, e);
        end
      end
    end
  end

  // ---------------- phase timing, SDA legality, first event, flags ----------------
  bit meas_on = 0, run_valid = 0, m_prev_scl = 1, m_prev_sda = 1;
  int run = 0, hi_min, hi_max, lo_min, lo_max, viol;
  bit watch = 0, w_prev_scl = 1, w_prev_sda = 1;
  int first_evt = 0;  // 1 = SCL moved first, 2 = SDA moved first
  int n_start = 0, n_stop = 0, n_both = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_seen) n_start++;
      if (stop_seen)  n_stop++;
      if (start_seen && stop_seen) n_both++;
    end
    if (meas_on) begin
      if (scl_line && m_prev_scl && (sda_line != m_prev_sda)) viol++;
      if (scl_line == m_prev_scl) run++;
      else begin
        if (run_valid) begin
          if (m_prev_scl) begin
            if (run < hi_min) hi_min = run;
            if (run > hi_max) hi_max = run;
          end else begin
            if (run < lo_min) lo_min = run;
            if (run > lo_max) lo_max = run;
          end
        end
        run = 1;
        run_valid = 1;
      end
    end
    if (watch && first_evt == 0) begin
      if (scl_line != w_prev_scl)      first_evt = 1;
      else if (sda_line != w_prev_sda) first_evt = 2;
    end
    m_prev_scl = scl_line;  m_prev_sda = sda_line;
    w_prev_scl = scl_line;  w_prev_sda = sda_line;
  end

  // ---------------- driver ----------------
  int busy_len;

  task automatic strobe(input int kind, input logic [7:0] d, input logic ackr, input bit noise);
    int guard;
    @(negedge clk);
    wr_data = d; rd_ack_req = ackr;
    case (kind)
      0: cmd_start = 1;
      1: cmd_stop = 1;
      2: cmd_write = 1;
      default: cmd_read = 1;
    endcase
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_write = 0; cmd_read = 0;
    chk(busy == 1'b1, "R2 busy in cycle after strobe", busy, 1);
    busy_len = 0; guard = 0;
    while (busy && guard < 5000) begin
      if (noise) begin
        if (busy_len == 10) begin
          cmd_start = 1; cmd_stop = 1; cmd_write = 1; cmd_read = 1;
          wr_data = ~d; rd_ack_req = ~ackr;
        end else begin
          cmd_start = 0; cmd_stop = 0; cmd_write = 0; cmd_read = 0;
        end
      end
      busy_len++;
      guard++;
      @(negedge clk);
    end
    cmd_start = 0; cmd_stop = 0; cmd_write = 0; cmd_read = 0;
  endtask

  task automatic meas_begin();
    hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0; viol = 0;
    run = 0; run_valid = 0; m_prev_scl = scl_line; m_prev_sda = sda_line;
    meas_on = 1;
  endtask

  task automatic byte_checks(input string what);
    meas_on = 0;
    chk(busy_len == BYTE_CYC, {"R10 busy length ", what}, busy_len, BYTE_CYC);
    chk(scl_line == 1'b1, {"R10 SCL released at end ", what}, scl_line, 1);
    chk(hi_min == HALF && hi_max == HALF, {"R6 SCL high phase ", what}, hi_max, HALF);
    chk(lo_min == 1 + HALF && lo_max == 1 + HALF, {"R6 SCL low phase ", what}, lo_max, 1 + HALF);
    chk(viol == 0, {"R6 SDA moved with SCL high ", what}, viol, 0);
    chk(mon_cnt == 9, {"R6 nine clocks seen ", what}, mon_cnt, 9);
  endtask

  task automatic do_write(input logic [7:0] d, input logic tgt_ack, input bit noise);
    int s0, p0;
    s0 = n_start; p0 = n_stop;
    tgt_bits = {8'hFF, ~tgt_ack};
    tgt_idx = 0;
    exp_q.push_back({d, ~tgt_ack});
    mon_cnt = 0;
    meas_begin();
    strobe(2, d, 1'b0, noise);
    byte_checks("write");
    chk(ack_rcvd == tgt_ack, "R7 ack_rcvd after send", ack_rcvd, tgt_ack);
    if (noise) begin
      chk(n_start == s0 && n_stop == p0, "R2 no condition from ignored strobes",
          n_start - s0 + n_stop - p0, 0);
    end
  endtask

  task automatic do_read(input logic [7:0] d, input logic ackr);
    tgt_bits = {d, 1'b1};
    tgt_idx = 0;
    exp_q.push_back({d, ~ackr});
    mon_cnt = 0;
    meas_begin();
    strobe(3, 8'h00, ackr, 0);
    byte_checks("read");
    chk(rd_data == d, "R8 rd_data after receive", rd_data, d);
  endtask

  task automatic do_start(input bit repeated);
    int s0;
    s0 = n_start;
    tgt_idx = 9; mon_cnt = 9;
    first_evt = 0; w_prev_scl = scl_line; w_prev_sda = sda_line; watch = 1;
    strobe(0, 8'h00, 1'b0, 0);
    repeat (4) @(negedge clk);
    watch = 0;
    if (repeated) begin
      chk(first_evt == 1, "R4 SCL pulled low first on repeated start", first_evt, 1);
      chk(n_start == s0 + 1, "R4 start_seen pulses once", n_start - s0, 1);
      chk(scl_line == 1'b1 && sda_line == 1'b0, "R4 lines after repeated start",
          {scl_line, sda_line}, 2'b10);
    end else begin
      chk(first_evt == 2, "R3 SDA falls first on fresh start", first_evt, 2);
      chk(n_start == s0 + 1, "R3 start_seen pulses once", n_start - s0, 1);
      chk(scl_line == 1'b1 && sda_line == 1'b0, "R3 lines after start",
          {scl_line, sda_line}, 2'b10);
    end
  endtask

  task automatic do_stop();
    int p0;
    p0 = n_stop;
    tgt_idx = 9; mon_cnt = 9;
    first_evt = 0; w_prev_scl = scl_line; w_prev_sda = sda_line; watch = 1;
    strobe(1, 8'h00, 1'b0, 0);
    repeat (4) @(negedge clk);
    watch = 0;
    chk(first_evt == 1, "R5 SCL pulled low first on stop", first_evt, 1);
    chk(n_stop == p0 + 1, "R5 stop_seen pulses once", n_stop - p0, 1);
    chk(scl_line == 1'b1 && sda_line == 1'b1, "R5 both lines high after stop",
        {scl_line, sda_line}, 2'b11);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
    chk(busy == 0, "R1 busy low in reset", busy, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(ack_rcvd == 0, "R1 ack_rcvd after reset", ack_rcvd, 0);
    chk(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
    chk(start_seen == 0 && stop_seen == 0, "R1 flags after reset",
        {start_seen, stop_seen}, 0);

    do_start(0);
    do_write(8'hA5, 1'b1, 0);
    do_write(8'h5A, 1'b0, 0);
    do_read(8'hC3, 1'b1);
    do_read(8'h5A, 1'b0);
    do_start(1);
    do_write(8'h3C, 1'b1, 1);   // R2: burst of strobes mid-byte
    chk(rd_data == 8'h5A, "R2 rd_data untouched by ignored read", rd_data, 8'h5A);
    do_stop();
    do_start(0);
    do_read(8'h96, 1'b1);
    do_write(8'h01, 1'b0, 0);
    do_stop();
    chk(n_both == 0, "R11 start and stop never together", n_both, 0);
    chk(exp_q.size() == 0, "R6 all frames observed", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule